// File: doc/BRIEF.md
# Fault Injection Glitch Sequencer

This block times a voltage fault-injection campaign against an external target. For each attempt it holds the target in reset, releases it, waits out a blanking period, and then arms a qualified falling-edge trigger on a target status pin. That pin idles high through a pull-up and is driven low once the target sets it up as an output. When a real falling edge is confirmed, the block waits a programmable offset and then raises a single active-high glitch-enable pulse of programmable width toward an external crowbar driver.

After every pulse the offset moves up by a programmable step, and the next attempt begins with a fresh target reset. The sweep ends when the next offset would pass the configured end value. A stop input aborts the campaign at once. An arm timeout returns the block to target reset when no trigger arrives, and it raises a sticky flag when that happens. The pin goes through a two-stage synchronizer and a stable-low qualifier. The block subtracts the latency of that path from the programmed offset, so offsets are measured from the clock edge that first samples the pin low.

All configuration comes in on a parallel port. It is captured when a campaign starts and holds still for the whole sweep.

Top module: `glitch_sweep_top`

## Requirements
- R1: When the synchronous reset is released, glitch_en, tgt_rst, busy, done and timeout_flag are all 0.
- R2: A start pulse sampled in idle captures the configuration and sets cur_offset to cfg_off_start. tgt_rst then rises on that same clock edge and stays high for max(cfg_rst_len,1) cycles. The same rule applies to every later attempt.
- R3: After tgt_rst falls, the trigger stays unarmed for max(cfg_blank,1) cycles. A pin that is already low when arming begins is not taken as a trigger.
- R4: A trigger fires only after the synchronized pin has been seen high while armed and then low for max(cfg_qual,1) consecutive cycles. A low pulse shorter than that does not fire.
- R5: glitch_en rises exactly max(off, max(cfg_qual,1)+2) clock cycles after the first edge that samples the pin low, where off is cur_offset.
- R6: glitch_en stays high for exactly max(cfg_width,1) cycles.
- R7: After each pulse the offset grows by cfg_off_step, with a step of 0 treated as 1. The next attempt starts with tgt_rst high on the same edge on which glitch_en falls. cur_offset shows the offset in use.
- R8: When the next offset would exceed cfg_off_end, including by overflowing the offset width, done rises and the block goes idle on the edge where glitch_en falls. If cfg_off_start > cfg_off_end at start, done rises with no reset pulse at all. done is cleared by the next accepted start.
- R9: If no trigger fires within max(cfg_timeout,1) armed cycles, the attempt goes back to target reset with the same offset and no glitch, and timeout_flag is set. The flag stays set until the next accepted start.
- R10: A stop sampled outside idle sends the block to idle on that edge: glitch_en, tgt_rst and busy are 0 one cycle later, and done stays 0. Stop wins over a simultaneous start.
- R11: glitch_en is high only in the inject phase, never while tgt_rst is high, and never before the trigger fires.
- R12: A start pulse while busy is ignored. The captured configuration and cur_offset stay as they were, and no new reset is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a campaign (sampled in idle) |
| stop | input | 1 | Abort the running campaign |
| cfg_off_start | input | OFF_W | First glitch offset in cycles |
| cfg_off_end | input | OFF_W | Last allowed glitch offset |
| cfg_off_step | input | OFF_W | Offset increment per attempt |
| cfg_width | input | WID_W | Glitch pulse width in cycles |
| cfg_rst_len | input | CNT_W | Target reset length in cycles |
| cfg_blank | input | CNT_W | Blanking time after reset release |
| cfg_timeout | input | TO_W | Armed-wait limit in cycles |
| cfg_qual | input | QUAL_W | Cycles the pin must stay low to qualify |
| trig_pin | input | 1 | Asynchronous target status pin |
| tgt_rst | output | 1 | Target reset drive, high = held in reset |
| glitch_en | output | 1 | Crowbar driver enable pulse |
| cur_offset | output | OFF_W | Offset used by the current attempt |
| busy | output | 1 | Campaign in progress |
| done | output | 1 | Sweep range exhausted |
| timeout_flag | output | 1 | An arm timeout occurred in this campaign |

## Verification
Some properties are checked by assertions on every cycle:
- glitch_en is confined to the inject phase and never overlaps tgt_rst.
- A stop clears both outputs on the next cycle.
- A confirmed trigger always leads into the delay phase.
- cur_offset never moves past the captured end value, and it rises on every advance.
- done is only ever seen while idle.
- The qualifier cannot fire while unarmed, and it fires only after a low history.

The exact cycle counts can only be shown by the bench scenarios. These are the reset length, the blanking window, the trigger-to-pulse offset with its latency clamp, and the pulse width. The bench sweeps several offset ranges, steps and qualifier lengths, including a zero step and an overflowing range. It also covers three further cases:
- an early low pin that must end in a timeout;
- a sub-threshold low blip;
- aborts in the reset and inject phases.

// File: rtl/gsq_pkg.sv
package gsq_pkg;

    // Phases of one campaign attempt
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RESET  = 3'd1,
        ST_BLANK  = 3'd2,
        ST_ARM    = 3'd3,
        ST_DELAY  = 3'd4,
        ST_INJECT = 3'd5
    } seq_state_t;

    // Flops in the pin synchronizer
    localparam int SYNC_STAGES = 2;
    // Edges from the first low sample to the earliest possible pulse, on top of the qualifier length
    localparam int FIRE_LAT = 2;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    // Reload value for a phase that lasts max(v,1) cycles
    function automatic int unsigned less_one_sat(input int unsigned v);
        return at_least_one(v) - 1;
    endfunction

    // Delay-phase reload value after the trigger fires, clamped at zero
    function automatic int unsigned delay_after_fire(input int unsigned off, input int unsigned qual);
        int unsigned lat;
        lat = at_least_one(qual) + FIRE_LAT;
        return (off >= lat) ? (off - lat) : 0;
    endfunction

endpackage

// File: rtl/gsq_trig_qual.sv
module gsq_trig_qual
    import gsq_pkg::*;
#(
    parameter int QUAL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_async,
    input  logic              arm,
    input  logic [QUAL_W-1:0] qual_len,
    output logic              fire
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    logic                   seen_high_q;
    logic [QUAL_W-1:0]      low_cnt_q;
    logic [QUAL_W-1:0]      need_m1;

    // Synchronizer chain, idle level high
    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b1;
        else     sync_q[0] <= pin_async;
    end

    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) sync_q[g] <= 1'b1;
            else     sync_q[g] <= sync_q[g-1];
        end
    end

    assign pin_s   = sync_q[SYNC_STAGES-1];
    assign need_m1 = (qual_len == '0) ? '0 : (qual_len - QUAL_W'(1));
    assign fire    = arm && seen_high_q && !pin_s && (low_cnt_q == need_m1);

    // A high level must be seen while armed before any low counts
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_high_q <= 1'b0;
            low_cnt_q   <= '0;
        end else if (!arm) begin
            seen_high_q <= 1'b0;
            low_cnt_q   <= '0;
        end else if (pin_s) begin
            seen_high_q <= 1'b1;
            low_cnt_q   <= '0;
        end else if (seen_high_q && (low_cnt_q != need_m1)) begin
            low_cnt_q   <= low_cnt_q + QUAL_W'(1);
        end
    end

    // R3: leaving the armed phase clears any partial qualification
    p_unarmed_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !arm |=> !fire);

    // R4: a multi-cycle qualifier only fires after an earlier low sample
    p_low_history_r4: assert property (@(posedge clk) disable iff (rst)
        (fire && (need_m1 != '0)) |-> !$past(pin_s));

endmodule

// File: rtl/gsq_downcnt.sv
module gsq_downcnt #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/gsq_offset_walk.sv
module gsq_offset_walk #(
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             advance,
    input  logic [OFF_W-1:0] start_val,
    input  logic [OFF_W-1:0] step_val,
    input  logic [OFF_W-1:0] end_val,
    output logic [OFF_W-1:0] cur,
    output logic             last
);

    logic [OFF_W-1:0] cur_q;
    logic [OFF_W-1:0] step_eff;
    logic [OFF_W:0]   sum;

    assign step_eff = (step_val == '0) ? OFF_W'(1) : step_val;
    assign sum      = {1'b0, cur_q} + {1'b0, step_eff};
    assign last     = (sum > {1'b0, end_val});
    assign cur      = cur_q;

    always_ff @(posedge clk) begin
        if (rst)          cur_q <= '0;
        else if (init)    cur_q <= start_val;
        else if (advance) cur_q <= sum[OFF_W-1:0];
    end

    // R7: every advance moves the offset strictly upward
    p_offset_rises_r7: assert property (@(posedge clk) disable iff (rst)
        (advance && !init) |=> (cur_q > $past(cur_q)));

endmodule

// File: rtl/glitch_sweep_top.sv
module glitch_sweep_top
    import gsq_pkg::*;
#(
    parameter int OFF_W  = 8,
    parameter int WID_W  = 8,
    parameter int CNT_W  = 8,
    parameter int TO_W   = 12,
    parameter int QUAL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [OFF_W-1:0]  cfg_off_start,
    input  logic [OFF_W-1:0]  cfg_off_end,
    input  logic [OFF_W-1:0]  cfg_off_step,
    input  logic [WID_W-1:0]  cfg_width,
    input  logic [CNT_W-1:0]  cfg_rst_len,
    input  logic [CNT_W-1:0]  cfg_blank,
    input  logic [TO_W-1:0]   cfg_timeout,
    input  logic [QUAL_W-1:0] cfg_qual,
    input  logic              trig_pin,
    output logic              tgt_rst,
    output logic              glitch_en,
    output logic [OFF_W-1:0]  cur_offset,
    output logic              busy,
    output logic              done,
    output logic              timeout_flag
);

    localparam int TMR_W = int'(max2(max2(OFF_W, WID_W), max2(CNT_W, TO_W))) + 1;

    // Configuration captured at campaign start
    typedef struct packed {
        logic [OFF_W-1:0]  off_end;
        logic [OFF_W-1:0]  off_step;
        logic [WID_W-1:0]  width;
        logic [CNT_W-1:0]  rst_len;
        logic [CNT_W-1:0]  blank;
        logic [TO_W-1:0]   timeout;
        logic [QUAL_W-1:0] qual;
    } cfg_t;

    cfg_t       cfg_q;
    seq_state_t state_q, nxt;

    logic             fire, arm;
    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic             walk_init, walk_step, walk_last;
    logic             latch, done_set, done_clr, to_set, to_clr;
    logic             glitch_q, tgt_rst_q, done_q, to_q;

    logic [TMR_W-1:0] ld_first_rst, ld_rst, ld_blank, ld_arm, ld_dly, ld_wid;

    assign ld_first_rst = TMR_W'(less_one_sat(32'(cfg_rst_len)));
    assign ld_rst       = TMR_W'(less_one_sat(32'(cfg_q.rst_len)));
    assign ld_blank     = TMR_W'(less_one_sat(32'(cfg_q.blank)));
    assign ld_arm       = TMR_W'(less_one_sat(32'(cfg_q.timeout)));
    assign ld_wid       = TMR_W'(less_one_sat(32'(cfg_q.width)));
    assign ld_dly       = TMR_W'(delay_after_fire(32'(cur_offset), 32'(cfg_q.qual)));

    assign arm = (state_q == ST_ARM);

    gsq_trig_qual #(.QUAL_W(QUAL_W)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .pin_async (trig_pin),
        .arm       (arm),
        .qual_len  (cfg_q.qual),
        .fire      (fire)
    );

    gsq_downcnt #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    gsq_offset_walk #(.OFF_W(OFF_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .init      (walk_init),
        .advance   (walk_step),
        .start_val (cfg_off_start),
        .step_val  (cfg_q.off_step),
        .end_val   (cfg_q.off_end),
        .cur       (cur_offset),
        .last      (walk_last)
    );

    // Next-phase and side-effect decode
    always_comb begin
        nxt       = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        walk_init = 1'b0;
        walk_step = 1'b0;
        latch     = 1'b0;
        done_set  = 1'b0;
        done_clr  = 1'b0;
        to_set    = 1'b0;
        to_clr    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start && !stop) begin
                    latch    = 1'b1;
                    done_clr = 1'b1;
                    to_clr   = 1'b1;
                    if (cfg_off_start > cfg_off_end) begin
                        done_set = 1'b1;
                    end else begin
                        nxt       = ST_RESET;
                        tmr_load  = 1'b1;
                        tmr_val   = ld_first_rst;
                        walk_init = 1'b1;
                    end
                end
            end
            ST_RESET: begin
                if (tmr_zero) begin
                    nxt      = ST_BLANK;
                    tmr_load = 1'b1;
                    tmr_val  = ld_blank;
                end
            end
            ST_BLANK: begin
                if (tmr_zero) begin
                    nxt      = ST_ARM;
                    tmr_load = 1'b1;
                    tmr_val  = ld_arm;
                end
            end
            ST_ARM: begin
                if (fire) begin
                    nxt      = ST_DELAY;
                    tmr_load = 1'b1;
                    tmr_val  = ld_dly;
                end else if (tmr_zero) begin
                    nxt      = ST_RESET;
                    tmr_load = 1'b1;
                    tmr_val  = ld_rst;
                    to_set   = 1'b1;
                end
            end
            ST_DELAY: begin
                if (tmr_zero) begin
                    nxt      = ST_INJECT;
                    tmr_load = 1'b1;
                    tmr_val  = ld_wid;
                end
            end
            ST_INJECT: begin
                if (tmr_zero) begin
                    if (walk_last) begin
                        nxt      = ST_IDLE;
                        done_set = 1'b1;
                    end else begin
                        nxt       = ST_RESET;
                        walk_step = 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = ld_rst;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
        // Abort overrides every other transition
        if (stop && (state_q != ST_IDLE)) begin
            nxt       = ST_IDLE;
            tmr_load  = 1'b0;
            walk_step = 1'b0;
            done_set  = 1'b0;
            to_set    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            glitch_q  <= 1'b0;
            tgt_rst_q <= 1'b0;
            done_q    <= 1'b0;
            to_q      <= 1'b0;
            cfg_q     <= '0;
        end else begin
            state_q   <= nxt;
            glitch_q  <= (nxt == ST_INJECT);
            tgt_rst_q <= (nxt == ST_RESET);
            if (done_clr) done_q <= 1'b0;
            if (done_set) done_q <= 1'b1;
            if (to_clr)   to_q   <= 1'b0;
            if (to_set)   to_q   <= 1'b1;
            if (latch) begin
                cfg_q.off_end  <= cfg_off_end;
                cfg_q.off_step <= cfg_off_step;
                cfg_q.width    <= cfg_width;
                cfg_q.rst_len  <= cfg_rst_len;
                cfg_q.blank    <= cfg_blank;
                cfg_q.timeout  <= cfg_timeout;
                cfg_q.qual     <= cfg_qual;
            end
        end
    end

    assign glitch_en    = glitch_q;
    assign tgt_rst      = tgt_rst_q;
    assign done         = done_q;
    assign timeout_flag = to_q;
    assign busy         = (state_q != ST_IDLE);

    // R11: the enable pulse exists only in the inject phase
    p_glitch_in_inject_r11: assert property (@(posedge clk) disable iff (rst)
        glitch_en |-> (state_q == ST_INJECT));

    // R11: never crowbar a target that is held in reset
    p_glitch_not_in_reset_r11: assert property (@(posedge clk) disable iff (rst)
        tgt_rst |-> !glitch_en);

    // R10: an abort clears both drives one cycle later
    p_stop_abort_r10: assert property (@(posedge clk) disable iff (rst)
        (stop && (state_q != ST_IDLE)) |=> (!glitch_en && !tgt_rst && (state_q == ST_IDLE)));

    // R5: a qualified trigger always starts the delay phase
    p_fire_to_delay_r5: assert property (@(posedge clk) disable iff (rst)
        (arm && fire && !stop) |=> (state_q == ST_DELAY));

    // R8: the running offset never leaves the captured range
    p_offset_bound_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cur_offset <= cfg_q.off_end));

    // R8: completion is reported only while idle
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: a timeout never coincides with an enable pulse
    p_timeout_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_flag) |-> (!glitch_en && tgt_rst));

endmodule

// File: tb/tb_glitch_sweep_top.sv
module tb_glitch_sweep_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst, start, stop, trig_pin;
    logic [7:0] cfg_off_start, cfg_off_end, cfg_off_step, cfg_width, cfg_rst_len, cfg_blank;
    logic [11:0] cfg_timeout;
    logic [2:0]  cfg_qual;
    logic        tgt_rst, glitch_en, busy, done, timeout_flag;
    logic [7:0]  cur_offset;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    glitch_sweep_top dut (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .cfg_off_start(cfg_off_start), .cfg_off_end(cfg_off_end), .cfg_off_step(cfg_off_step),
        .cfg_width(cfg_width), .cfg_rst_len(cfg_rst_len), .cfg_blank(cfg_blank),
        .cfg_timeout(cfg_timeout), .cfg_qual(cfg_qual), .trig_pin(trig_pin),
        .tgt_rst(tgt_rst), .glitch_en(glitch_en), .cur_offset(cur_offset),
        .busy(busy), .done(done), .timeout_flag(timeout_flag)
    );

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check_eq(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int s, input int e, input int st, input int w,
                           input int r, input int b, input int t, input int q);
        cfg_off_start = 8'(s);  cfg_off_end = 8'(e);  cfg_off_step = 8'(st);
        cfg_width = 8'(w);      cfg_rst_len = 8'(r);  cfg_blank = 8'(b);
        cfg_timeout = 12'(t);   cfg_qual = 3'(q);
    endtask

    // Returns at the first negedge after the edge that accepted start
    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // Called while tgt_rst is high; returns once arming is certain
    task automatic reset_phase(input int off, input int r, input int b);
        int n = 0;
        check_eq("R7 cur_offset readback", int'(cur_offset), off);
        while (tgt_rst && n < 1000) begin n++; @(negedge clk); end
        check_eq("R2 target reset length", n, imax(r, 1));
        repeat (imax(b, 1) + 1) @(negedge clk);
        check_eq("R11 no glitch before trigger", int'(glitch_en), 0);
    endtask

    task automatic fire_phase(input int off, input int q, input int w, input bit last);
        int idx = 0;
        int wid = 0;
        trig_pin = 1'b0;
        @(negedge clk);
        while (!glitch_en && idx < 1000) begin idx++; @(negedge clk); end
        check_eq("R5 trigger to glitch offset", idx, imax(off, imax(q, 1) + 2));
        while (glitch_en && wid < 1000) begin wid++; @(negedge clk); end
        check_eq("R6 glitch width", wid, imax(w, 1));
        trig_pin = 1'b1;
        if (last) begin
            check_eq("R8 done after last offset", int'(done), 1);
            check_eq("R8 idle after last offset", int'(busy), 0);
        end else begin
            check_eq("R7 next attempt starts with reset", int'(tgt_rst), 1);
        end
    endtask

    task automatic run_sweep(input int s, input int e, input int st, input int w,
                             input int r, input int b, input int q);
        int o = s;
        int stp = (st == 0) ? 1 : st;
        set_cfg(s, e, st, w, r, b, 60, q);
        pulse_start();
        check_eq("R2 reset rises after start", int'(tgt_rst), 1);
        check_eq("R8 done cleared by start", int'(done), 0);
        while (o <= e) begin
            reset_phase(o, r, b);
            fire_phase(o, q, w, (o + stp) > e);
            o += stp;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        bit saw;
        rst = 1'b1; start = 1'b0; stop = 1'b0; trig_pin = 1'b1;
        set_cfg(0, 0, 1, 1, 1, 1, 60, 1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 glitch_en after reset", int'(glitch_en), 0);
        check_eq("R1 tgt_rst after reset", int'(tgt_rst), 0);
        check_eq("R1 busy after reset", int'(busy), 0);
        check_eq("R1 done after reset", int'(done), 0);
        check_eq("R1 timeout_flag after reset", int'(timeout_flag), 0);

        // Offset sweeps, including offsets below the latency clamp
        run_sweep(2, 9, 1, 3, 3, 2, 2);
        run_sweep(5, 17, 4, 1, 0, 0, 0);
        run_sweep(250, 255, 3, 5, 2, 1, 3);   // next offset overflows 8 bits
        run_sweep(20, 22, 0, 2, 1, 1, 1);     // zero step acts as one
        run_sweep(11, 11, 1, 7, 4, 3, 7);

        // R9 / R3: pin low during blanking must not trigger; timeout retries
        set_cfg(6, 6, 1, 2, 2, 3, 10, 2);
        pulse_start();
        n = 0;
        while (tgt_rst && n < 100) begin n++; @(negedge clk); end
        trig_pin = 1'b0;
        saw = 1'b0;
        n = 0;
        @(negedge clk);
        while (!tgt_rst && n < 200) begin
            if (glitch_en) saw = 1'b1;
            n++;
            @(negedge clk);
        end
        check_eq("R3 early low pin ignored, reset retried", int'(tgt_rst), 1);
        check_eq("R9 no glitch on timeout", int'(saw), 0);
        check_eq("R9 timeout flag set", int'(timeout_flag), 1);
        check_eq("R9 offset kept after timeout", int'(cur_offset), 6);
        trig_pin = 1'b1;
        reset_phase(6, 2, 3);
        fire_phase(6, 2, 2, 1'b1);
        check_eq("R9 timeout flag sticky", int'(timeout_flag), 1);
        pulse_start();
        check_eq("R9 timeout flag cleared by start", int'(timeout_flag), 0);
        stop = 1'b1;
        @(negedge clk) stop = 1'b0;

        // R4: a low blip shorter than the qualifier is ignored
        set_cfg(7, 7, 1, 2, 2, 2, 60, 3);
        pulse_start();
        n = 0;
        while (tgt_rst && n < 100) begin n++; @(negedge clk); end
        repeat (3) @(negedge clk);
        trig_pin = 1'b0;
        repeat (2) @(negedge clk);
        trig_pin = 1'b1;
        saw = 1'b0;
        repeat (8) begin
            @(negedge clk);
            if (glitch_en) saw = 1'b1;
        end
        check_eq("R4 short low blip does not fire", int'(saw), 0);
        fire_phase(7, 3, 2, 1'b1);

        // R10: stop during inject
        set_cfg(8, 20, 1, 20, 2, 2, 60, 1);
        pulse_start();
        reset_phase(8, 2, 2);
        trig_pin = 1'b0;
        n = 0;
        while (!glitch_en && n < 200) begin n++; @(negedge clk); end
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk) stop = 1'b0;
        check_eq("R10 stop drops glitch_en", int'(glitch_en), 0);
        check_eq("R10 stop leaves tgt_rst low", int'(tgt_rst), 0);
        check_eq("R10 stop ends busy", int'(busy), 0);
        check_eq("R10 stop does not set done", int'(done), 0);
        trig_pin = 1'b1;

        // R10: stop beats a simultaneous start
        @(negedge clk) begin start = 1'b1; stop = 1'b1; end
        @(negedge clk) begin start = 1'b0; stop = 1'b0; end
        check_eq("R10 stop wins over start", int'(busy), 0);
        check_eq("R10 no reset when stop wins", int'(tgt_rst), 0);

        // R10: stop during target reset
        pulse_start();
        check_eq("R2 reset high before abort", int'(tgt_rst), 1);
        stop = 1'b1;
        @(negedge clk) stop = 1'b0;
        check_eq("R10 stop releases target reset", int'(tgt_rst), 0);

        // R12: start while busy is ignored
        pulse_start();
        n = 0;
        while (tgt_rst && n < 100) begin n++; @(negedge clk); end
        cfg_off_start = 8'd15;
        cfg_width = 8'd1;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        check_eq("R12 no new reset on busy start", int'(tgt_rst), 0);
        check_eq("R12 offset kept on busy start", int'(cur_offset), 8);
        repeat (3) @(negedge clk);
        fire_phase(8, 1, 20, 1'b0);
        stop = 1'b1;
        @(negedge clk) stop = 1'b0;

        // R8: start above end finishes immediately
        set_cfg(9, 3, 1, 2, 2, 2, 60, 1);
        pulse_start();
        check_eq("R8 empty range sets done", int'(done), 1);
        check_eq("R8 empty range stays idle", int'(busy), 0);
        check_eq("R8 empty range issues no reset", int'(tgt_rst), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule